// File: doc/BRIEF.md
# Conflict-Allocating Instruction Cache

This block sits between a program sequencer and a program-memory bus that is shared between instruction fetches and data operands. Most fetches go straight to that bus and are never kept. An instruction is written into the cache only when its fetch arrives in the same cycle as a data access on the shared bus. When that happens the data access keeps the bus, the fetch waits one cycle, is read from the bus, and is kept. When a tight loop such as a multiply-accumulate kernel runs again, the cache supplies the kept instructions. The bus then stays free for the second data operand, and one instruction plus two operands move in a single cycle.

The cache holds 32 entries of 48-bit instructions in 16 sets of 2 ways. A set picks its victim from least-recent use. A synchronous flush clears every entry. A disable input sends every fetch to the bus and blocks allocation; entries already held are kept.

On the fetch side, `fetch_valid`/`fetch_ready` form a valid/ready handshake. The sequencer holds `fetch_addr` and `pm_data_req` steady while `fetch_valid` is high and `fetch_ready` is low. A fetch is accepted on the clock edge where both are high. The instruction return (`instr_valid`) and the bus return (`bus_rvalid`) carry no back-pressure: each lasts one cycle and must be taken in that cycle. Only one fetch is in flight at a time.

Top module: `icache_sel`

## Requirements
- R1: After reset, `fetch_ready` is 1 and both `instr_valid` and `bus_req` are 0.
- R2: A miss accepted while `pm_data_req` is 0 raises `bus_req` for one cycle, in the cycle after acceptance, with `bus_addr` equal to the fetch address. It allocates nothing, so the same fetch repeated without a data access goes to the bus again.
- R3: A miss accepted while `pm_data_req` is 1 leaves `bus_req` low for one stall cycle and raises it in the second cycle after acceptance. The returned word is then written into the cache.
- R4: A hit, whether or not `pm_data_req` is 1, raises `instr_valid` in the cycle after acceptance with the stored word and raises no `bus_req`.
- R5: `fetch_ready` is 0 from the cycle after a miss is accepted until the cycle in which its instruction is returned.
- R6: `instr_valid` rises in the cycle after `bus_rvalid` with the word that was on `bus_rdata`.
- R7: Two addresses with the same index bits (`fetch_addr[3:0]`) can be held at the same time, one per way.
- R8: When a set is full, a fill replaces the way that was not used most recently. Both hits and fills count as use.
- R9: A one-cycle `flush` invalidates all entries, so the next fetch of any address misses.
- R10: While `cache_dis` is 1, every fetch goes to the bus, including addresses held in the cache, and nothing is allocated even on a conflict. The stall cycle of R3 still applies. Entries held before the disable still hit after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Sequencer offers a fetch |
| fetch_ready | output | 1 | Cache can accept a fetch |
| fetch_addr | input | 24 | Instruction address |
| pm_data_req | input | 1 | A data access wants the program-memory bus this cycle |
| flush | input | 1 | Invalidate all entries |
| cache_dis | input | 1 | Bypass lookup and block allocation |
| instr_valid | output | 1 | Instruction word returned (one cycle) |
| instr_data | output | 48 | Returned instruction word |
| bus_req | output | 1 | Instruction read on the program-memory bus |
| bus_addr | output | 24 | Address of that read |
| bus_rvalid | input | 1 | Bus read data present |
| bus_rdata | input | 48 | Bus read data |

## Verification
The assertions check the following on every cycle, using only the pins:
- A fetch accepted without a data access is answered either by a return or by a bus request in the next cycle, never both.
- A conflicting fetch never drives the bus in the next cycle.
- The bus request lasts one cycle and only while `fetch_ready` is low.
- A bus return is forwarded in the next cycle with its data.
- A disabled fetch is never answered from the cache.

Some behaviours depend on history and can only be shown by the bench's scenarios:
- whether an entry was allocated or not;
- which way least-recent use evicts;
- that a flush empties the cache;
- that entries survive a disable period.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int IC_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STALL,
    ST_ISSUE,
    ST_WAIT
  } ic_state_e;
endpackage

// File: rtl/icache_way.sv
module icache_way #(
  parameter int SETS   = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              probe_valid
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  // flush wins over a fill landing in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q <= '0;
    else if (flush) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign hit         = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign rd_data     = data_q[lk_idx];
  assign probe_valid = valid_q[wr_idx];
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             victim
);
  // one bit per set: the way to replace next
  logic [SETS-1:0] next_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        next_q <= '0;
    else if (flush)    next_q <= '0;
    else if (touch_en) next_q[touch_idx] <= ~touch_way;
  end

  assign victim = next_q[rd_idx];
endmodule

// File: rtl/icache_sel.sv
module icache_sel
  import icache_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 48,
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              pm_data_req,
  input  logic              flush,
  input  logic              cache_dis,
  output logic              instr_valid,
  output logic [DATA_W-1:0] instr_data,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int SETS  = ENTRIES / IC_WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  ic_state_e         state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              alloc_q;

  logic [IC_WAYS-1:0] way_hit;
  logic [IC_WAYS-1:0] way_pv;
  logic [DATA_W-1:0]  way_data [IC_WAYS];

  logic [IDX_W-1:0] lk_idx, req_idx;
  logic [TAG_W-1:0] lk_tag, req_tag;
  logic accept, hit, hit_way, fill, lru_victim, victim_way;
  logic touch_en, touch_way;
  logic [IDX_W-1:0] touch_idx;

  assign lk_idx  = fetch_addr[IDX_W-1:0];
  assign lk_tag  = fetch_addr[ADDR_W-1:IDX_W];
  assign req_idx = req_addr_q[IDX_W-1:0];
  assign req_tag = req_addr_q[ADDR_W-1:IDX_W];

  assign fetch_ready = (state_q == ST_IDLE);
  assign accept      = fetch_valid && fetch_ready;
  assign hit         = (|way_hit) && !cache_dis && !flush;
  assign hit_way     = way_hit[1];
  assign fill        = (state_q == ST_WAIT) && bus_rvalid && alloc_q;

  // empty way first, else the least recently used one
  always_comb begin
    if (!way_pv[0])      victim_way = 1'b0;
    else if (!way_pv[1]) victim_way = 1'b1;
    else                 victim_way = lru_victim;
  end

  assign touch_en  = (accept && hit) || fill;
  assign touch_idx = fill ? req_idx : lk_idx;
  assign touch_way = fill ? victim_way : hit_way;

  for (genvar w = 0; w < IC_WAYS; w++) begin : g_way
    icache_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_way (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .lk_idx     (lk_idx),
      .lk_tag     (lk_tag),
      .hit        (way_hit[w]),
      .rd_data    (way_data[w]),
      .wr_en      (fill && (victim_way == 1'(w))),
      .wr_idx     (req_idx),
      .wr_tag     (req_tag),
      .wr_data    (bus_rdata),
      .probe_valid(way_pv[w])
    );
  end

  icache_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .touch_en (touch_en),
    .touch_idx(touch_idx),
    .touch_way(touch_way),
    .rd_idx   (req_idx),
    .victim   (lru_victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      alloc_q     <= 1'b0;
      instr_valid <= 1'b0;
      instr_data  <= '0;
    end else begin
      instr_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          req_addr_q <= fetch_addr;
          if (hit) begin
            instr_valid <= 1'b1;
            instr_data  <= hit_way ? way_data[1] : way_data[0];
          end else if (pm_data_req) begin
            state_q <= ST_STALL;          // data access owns the bus
            alloc_q <= !cache_dis;
          end else begin
            state_q <= ST_ISSUE;
            alloc_q <= 1'b0;
          end
        end
        ST_STALL: state_q <= ST_ISSUE;
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (bus_rvalid) begin
          instr_valid <= 1'b1;
          instr_data  <= bus_rdata;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req  = (state_q == ST_ISSUE);
  assign bus_addr = req_addr_q;
endmodule

// File: rtl/icache_sel_chk.sv
module icache_sel_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              pm_data_req,
  input logic              cache_dis,
  input logic              instr_valid,
  input logic [DATA_W-1:0] instr_data,
  input logic              bus_req,
  input logic              bus_rvalid,
  input logic [DATA_W-1:0] bus_rdata
);
  // R2 / R4: a clean fetch is served by exactly one path next cycle
  a_r2_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && !pm_data_req |=> (instr_valid ^ bus_req));

  // R3: a conflicting fetch never takes the bus in the following cycle
  a_r3_stall: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && pm_data_req |=> !bus_req);

  // R5: the bus request is a single pulse during a busy period
  a_r5_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !fetch_ready);
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);

  // R6: bus return forwarded one cycle later
  a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid && !fetch_ready |=> instr_valid && (instr_data == $past(bus_rdata)));

  // R10: a disabled fetch is never answered from the cache
  a_r10_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && cache_dis |=> !instr_valid);
endmodule

bind icache_sel icache_sel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_valid(fetch_valid),
  .fetch_ready(fetch_ready),
  .pm_data_req(pm_data_req),
  .cache_dis  (cache_dis),
  .instr_valid(instr_valid),
  .instr_data (instr_data),
  .bus_req    (bus_req),
  .bus_rvalid (bus_rvalid),
  .bus_rdata  (bus_rdata)
);

// File: tb/icache_sel_test.sv
module icache_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [23:0] fetch_addr = '0;
  logic        pm_data_req = 1'b0;
  logic        flush = 1'b0;
  logic        cache_dis = 1'b0;
  logic        instr_valid;
  logic [47:0] instr_data;
  logic        bus_req;
  logic [23:0] bus_addr;
  logic        bus_rvalid;
  logic [47:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  icache_sel uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .pm_data_req(pm_data_req), .flush(flush),
    .cache_dis(cache_dis), .instr_valid(instr_valid), .instr_data(instr_data),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  function automatic logic [47:0] word_of(input logic [23:0] a);
    return {a, a ^ 24'h5A3C96};
  endfunction

  // program memory: answers one cycle after each request
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_req;
      bus_rdata  <= word_of(bus_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one fetch; lat counts negedges from acceptance to the returned word
  task automatic fetch_chk(input logic [23:0] a, input bit dreq,
                           input int exp_lat, input int exp_bus, input string req);
    int lat = 1;
    int nbus = 0;
    int rdy_hi = 0;
    logic [23:0] seen = '0;
    @(negedge clk);
    chk(fetch_ready, "R5", "ready before fetch", 64'(fetch_ready), 64'd1);
    fetch_valid = 1'b1; fetch_addr = a; pm_data_req = dreq;
    @(posedge clk);
    @(negedge clk);
    fetch_valid = 1'b0; pm_data_req = 1'b0;
    while (!instr_valid && lat < 20) begin
      if (bus_req) begin nbus++; seen = bus_addr; end
      if (fetch_ready) rdy_hi++;
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, req, "latency", 64'(lat), 64'(exp_lat));
    chk(nbus == exp_bus, req, "bus requests", 64'(nbus), 64'(exp_bus));
    chk(instr_data == word_of(a), "R6", "instruction word", 64'(instr_data), 64'(word_of(a)));
    if (nbus > 0) begin
      chk(seen == a, "R2", "bus address", 64'(seen), 64'(a));
      chk(rdy_hi == 0, "R5", "ready while busy", 64'(rdy_hi), 64'd0);
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  localparam logic [23:0] A = 24'h000010, B = 24'h000020, C = 24'h000030, D = 24'h000105;

  task automatic t_reset();
    @(negedge clk);
    chk(fetch_ready == 1'b1, "R1", "ready", 64'(fetch_ready), 64'd1);
    chk(instr_valid == 1'b0, "R1", "instr_valid", 64'(instr_valid), 64'd0);
    chk(bus_req == 1'b0, "R1", "bus_req", 64'(bus_req), 64'd0);
  endtask

  task automatic t_plain_miss();
    fetch_chk(D, 1'b0, 3, 1, "R2");
    fetch_chk(D, 1'b0, 3, 1, "R2");   // not allocated
  endtask

  task automatic t_conflict();
    fetch_chk(A, 1'b1, 4, 1, "R3");   // stall then fill
    fetch_chk(A, 1'b0, 1, 0, "R4");
    fetch_chk(A, 1'b1, 1, 0, "R4");   // hit beside a data access
  endtask

  task automatic t_ways_lru();
    fetch_chk(B, 1'b1, 4, 1, "R7");
    fetch_chk(A, 1'b0, 1, 0, "R7");
    fetch_chk(B, 1'b0, 1, 0, "R7");   // A now least recent
    fetch_chk(C, 1'b1, 4, 1, "R8");   // evicts A
    fetch_chk(B, 1'b0, 1, 0, "R8");
    fetch_chk(C, 1'b0, 1, 0, "R8");
    fetch_chk(A, 1'b0, 3, 1, "R8");
  endtask

  task automatic t_disable();
    cache_dis = 1'b1;
    fetch_chk(B, 1'b0, 3, 1, "R10");
    fetch_chk(D, 1'b1, 4, 1, "R10");
    cache_dis = 1'b0;
    fetch_chk(D, 1'b0, 3, 1, "R10");  // was not allocated
    fetch_chk(B, 1'b0, 1, 0, "R10");  // kept through disable
  endtask

  task automatic t_flush();
    do_flush();
    fetch_chk(B, 1'b0, 3, 1, "R9");
    fetch_chk(C, 1'b0, 3, 1, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_plain_miss();
    t_conflict();
    t_ways_lru();
    t_disable();
    t_flush();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule